// File: doc/BRIEF.md
# Grouped One-Hot Select Register

This block is an output register fed by a set of enable/data pairs. The enables are split into contiguous groups. Inside a group the enables are expected to be zero-or-one-hot. The group's candidate word is therefore the AND-OR merge of its members: each data word is masked by its own enable, and the masked words are ORed together. No priority chain is built inside a group. Between groups a fixed order applies: the group holding the lowest enable indices wins.

When no enable is active, an elaboration-time choice decides what the register does. It either keeps its value or loads zero. A run-time checker watches every group. If any group ever has two or more enables high, a registered, sticky error flag is raised. The output during such a cycle is still well defined: it is the OR of all the enabled words in the winning group.

A typical use is a wide bus register written from several mutually exclusive sources, where the merge logic must stay shallow and the exclusivity assumption must still be policed.

Top module: `grp_sel_reg`

## Requirements
- R1: An active-low asynchronous reset forces `q_o` to all zeros and `err_o` to 0.
- R2: In hold mode (`IDLE` = `IDLE_HOLD`), a clock edge with every enable low leaves `q_o` unchanged.
- R3: Data for enable k sits at `data_i[k*DW +: DW]`. On the edge after a single enable k is high, `q_o` equals that word.
- R4: In clear mode (`IDLE` = `IDLE_CLEAR`), a clock edge with every enable low loads zero into `q_o`.
- R5: Groups are contiguous. Group g starts at index `GRP_LO[g*8 +: 8]`, and the last group ends at `N_EN-1`. When several groups have an active enable, the group with the lowest index wins. With the defaults, the groups are {0,1,2}, {3,4,5} and {6}.
- R6: If any group has two or more enables high on an edge, `err_o` is 1 from the following edge on and stays 1 until reset.
- R7: When the winning group has several enables high, `q_o` becomes the bitwise OR of the data words of all of its active enables.
- R8: By default the block is built with `DW` = 64 and `N_EN` = 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | N_EN | Enable per source |
| data_i | input | N_EN*DW | Source words, word k at bits k*DW upward |
| q_o | output | DW | Registered selected word |
| err_o | output | 1 | Sticky flag: some group was not zero-or-one-hot |

## Verification
The bench instantiates the block twice with the default 64-bit width and the default three groups: 0–2, 3–5 and the lone enable 6. One instance uses hold mode and the other clear mode, and both receive the same stimulus. Every idle cycle therefore exercises both idle behaviours side by side, and the cross-group priority is reached with all three groups active at once. A reference model with explicit priority is compared against both outputs. It runs under random per-group one-hot patterns and under deliberate multi-hot patterns that exercise the OR result and the sticky error.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  typedef enum logic {
    IDLE_HOLD  = 1'b0,
    IDLE_CLEAR = 1'b1
  } idle_e;

  // Start index of group g, read from a packed list of 8-bit bounds.
  function automatic int grp_start(input logic [255:0] lo_list, input int g);
    return int'(lo_list[g*8 +: 8]);
  endfunction

  // Nonzero when more than one bit of v is set.
  function automatic logic multi_hot(input logic [63:0] v);
    return (v & (v - 64'd1)) != 64'd0;
  endfunction

endpackage

// File: rtl/gsr_group_merge.sv
module gsr_group_merge #(
  parameter int DW = 64,
  parameter int W  = 3
) (
  input  logic [W-1:0]    en_i,
  input  logic [W*DW-1:0] data_i,
  output logic            hit_o,
  output logic            multi_o,
  output logic [DW-1:0]   word_o
);
  import gsr_pkg::*;

  logic [DW-1:0] acc;

  // AND-OR merge: no priority among members of the group.
  always_comb begin
    acc = '0;
    for (int k = 0; k < W; k++) begin
      acc = acc | ({DW{en_i[k]}} & data_i[k*DW +: DW]);
    end
  end

  assign word_o  = acc;
  assign hit_o   = |en_i;
  assign multi_o = multi_hot(64'(en_i));

endmodule

// File: rtl/gsr_prio_pick.sv
module gsr_prio_pick #(
  parameter int DW    = 64,
  parameter int N_GRP = 3
) (
  input  logic [N_GRP-1:0]    hit_i,
  input  logic [N_GRP*DW-1:0] word_i,
  output logic                any_o,
  output logic [DW-1:0]       word_o
);
  // Walk from the lowest-priority group up, so the lowest index wins.
  always_comb begin
    word_o = '0;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      if (hit_i[g]) word_o = word_i[g*DW +: DW];
    end
  end

  assign any_o = |hit_i;

endmodule

// File: rtl/grp_sel_reg.sv
module grp_sel_reg
  import gsr_pkg::*;
#(
  parameter int                 DW     = 64,
  parameter int                 N_EN   = 7,
  parameter int                 N_GRP  = 3,
  parameter logic [N_GRP*8-1:0] GRP_LO = {8'd6, 8'd3, 8'd0},
  parameter idle_e              IDLE   = IDLE_HOLD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EN-1:0]    en_i,
  input  logic [N_EN*DW-1:0] data_i,
  output logic [DW-1:0]      q_o,
  output logic               err_o
);
  localparam logic [255:0] LO_EXT = 256'(GRP_LO);

  logic [N_GRP-1:0]    grp_hit;
  logic [N_GRP-1:0]    grp_multi;
  logic [N_GRP*DW-1:0] grp_word;
  logic [DW-1:0]       pick_word;
  logic                load_evt;
  logic                idle_evt;
  logic                viol_evt;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = grp_start(LO_EXT, g);
    localparam int HI = (g == N_GRP - 1) ? N_EN - 1 : grp_start(LO_EXT, g + 1) - 1;
    localparam int W  = HI - LO + 1;

    gsr_group_merge #(.DW(DW), .W(W)) u_merge (
      .en_i    (en_i[HI:LO]),
      .data_i  (data_i[HI*DW+DW-1 : LO*DW]),
      .hit_o   (grp_hit[g]),
      .multi_o (grp_multi[g]),
      .word_o  (grp_word[g*DW +: DW])
    );
  end

  gsr_prio_pick #(.DW(DW), .N_GRP(N_GRP)) u_pick (
    .hit_i  (grp_hit),
    .word_i (grp_word),
    .any_o  (load_evt),
    .word_o (pick_word)
  );

  assign idle_evt = ~load_evt;
  assign viol_evt = |grp_multi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (load_evt) begin
      q_o <= pick_word;
    end else if (IDLE == IDLE_CLEAR) begin
      q_o <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else if (viol_evt) err_o <= 1'b1;
  end

  // R1: while reset is held, both outputs are zero.
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (q_o == '0 && !err_o));

  // R2: hold mode keeps the word across an idle edge.
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (IDLE == IDLE_HOLD && en_i == '0) |=> $stable(q_o));

  // R4: clear mode zeroes the word after an idle edge.
  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (IDLE == IDLE_CLEAR && en_i == '0) |=> (q_o == '0));

  // R6: any group violation raises the flag on the next edge.
  p_viol_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> err_o);

  // R6: the flag never drops without reset.
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

// File: tb/grp_sel_reg_bench.sv
`timescale 1ns/1ps
module grp_sel_reg_bench;
  import gsr_pkg::*;

  localparam int DW = 64;
  localparam int NE = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NE-1:0]   en = '0;
  logic [NE*DW-1:0] data = '0;
  logic [DW-1:0]   q_h, q_c;
  logic            err_h, err_c;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  logic [DW-1:0] exp_h = '0, exp_c = '0;
  logic          exp_err = 1'b0;

  always #2.5 clk = ~clk;

  grp_sel_reg u_grp_sel_reg (
    .clk(clk), .rst_n(rst_n), .en_i(en), .data_i(data), .q_o(q_h), .err_o(err_h));

  grp_sel_reg #(.IDLE(IDLE_CLEAR)) u_grp_sel_reg_clr (
    .clk(clk), .rst_n(rst_n), .en_i(en), .data_i(data), .q_o(q_c), .err_o(err_c));

  function automatic logic [DW-1:0] or_range(input logic [NE-1:0] e,
      input logic [NE*DW-1:0] d, input int lo, input int hi);
    logic [DW-1:0] r = '0;
    for (int k = lo; k <= hi; k++) if (e[k]) r = r | d[k*DW +: DW];
    return r;
  endfunction

  // Reference with explicit priority between groups {0..2}, {3..5}, {6}.
  function automatic logic [DW-1:0] ref_next(input logic [NE-1:0] e,
      input logic [NE*DW-1:0] d, input logic [DW-1:0] prev, input bit clr);
    if (e[2:0] != 0)      return or_range(e, d, 0, 2);
    else if (e[5:3] != 0) return or_range(e, d, 3, 5);
    else if (e[6])        return d[6*DW +: DW];
    else if (clr)         return '0;
    else                  return prev;
  endfunction

  function automatic bit many(input logic [NE-1:0] v);
    return $countones(v) > 1;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " hold q"}, q_h, exp_h);
    chk({tag, " clear q"}, q_c, exp_c);
    chk({tag, " hold err"}, 64'(err_h), 64'(exp_err));
    chk({tag, " clear err"}, 64'(err_c), 64'(exp_err));
  endtask

  task automatic step(input logic [NE-1:0] e, input string tag);
    @(negedge clk);
    en = e;
    for (int k = 0; k < NE; k++) data[k*DW +: DW] = {$urandom, $urandom};
    exp_h = ref_next(e, data, exp_h, 1'b0);
    exp_c = ref_next(e, data, exp_c, 1'b1);
    if (many(e[2:0]) || many(e[5:3])) exp_err = 1'b1;
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_h = '0; exp_c = '0; exp_err = 1'b0;
    #1;
    compare_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    for (int k = 0; k < NE; k++) step(NE'(1) << k, "R3 single enable");
  endtask

  task automatic t_idle();
    step(7'b0000010, "R3 load before idle");
    step(7'b0000000, "R2 R4 idle edge");
    step(7'b0000000, "R2 R4 second idle edge");
  endtask

  task automatic t_priority();
    step(7'b1001001, "R5 all groups, first wins");
    step(7'b1010000, "R5 second over lone");
    step(7'b1000000, "R5 lone enable");
    step(7'b0100100, "R5 group one member 2");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [NE-1:0] e = '0;
      int a = $urandom % 4;
      int b = $urandom % 4;
      if (a < 3) e[a] = 1'b1;
      if (b < 3) e[3 + b] = 1'b1;
      e[6] = $urandom % 2;
      step(e, "R3 R5 random one-hot");
    end
  endtask

  task automatic t_violation();
    step(7'b0000011, "R6 R7 group0 multi-hot");
    step(7'b0000000, "R6 sticky after idle");
    step(7'b0111000, "R7 group1 triple");
    step(7'b0000100, "R6 sticky on legal");
    t_reset();
    step(7'b0001000, "R1 flag cleared by reset");
  endtask

  initial begin
    #1;
    compare_all("R1 reset at start");
    chk("R8 data width", 64'($bits(q_h)), 64'd64);
    chk("R8 enable count", 64'($bits(en)), 64'd7);
    @(negedge clk);
    rst_n = 1'b1;
    t_single();
    t_idle();
    t_priority();
    t_random();
    t_idle();
    t_violation();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule